// File: doc/BRIEF.md
# Delayed Request Discard Timers

This block supervises the delayed requests waiting on both sides of a two-port bus bridge. Each side has a timer. It starts counting bus clocks when a delayed request becomes the head entry of that side's queue. If the initiator that issued the request comes back and repeats it, that timer stops. If the initiator does not repeat it in time, the block raises a one-cycle discard pulse, and the queue pops that entry.

Each side selects its own limit: a long window of 2^15 clocks or a short window of 2^10 clocks. Every expiry sets two sticky status flags, and software clears them by writing ones. When the error-report enable is set, an expiry also drives a one-cycle low pulse on an active-low system error output. The block has no queue storage, no bus protocol decoding and no clock crossing. It takes head-valid and repeat-seen indications from the queue logic.

Top module: `drq_discard_timers`

## Requirements
- R1: After reset, every control and status bit reads 0, both discard outputs are 0 and `serr_n` is 1.
- R2: With a side's select at 0 (long), its discard output is 1 in the cycle after the 32768th rising edge at which that side's head-valid was sampled high, and 0 before that.
- R3: With a side's select at 1 (short), the discard output is 1 after the 1024th such edge, and 0 before that.
- R4: A discard pulse lasts exactly one cycle. If head-valid stays high, the next entry is timed from zero, so the next pulse comes 1024 (short) edges later.
- R5: A repeat seen while head-valid is high clears and stops that side's counter. No discard occurs while that entry stays at the head. Once head-valid has been low for at least one edge, a new entry is timed from zero.
- R6: A repeat sampled at the same edge at which the count would expire wins, and no discard is produced.
- R7: The register layout is bit 0 primary short select, bit 1 secondary short select, bit 2 error-report enable, bit 3 timeout status, bit 4 discard status. An expiry on either side sets bits 3 and 4 in the same cycle as the discard pulse. Writing 1 to bit 3 or bit 4 clears it, and writing 0 leaves it unchanged. Bits 0 to 2 take the written value.
- R8: If an expiry and a write that clears the status land on the same edge, the status bits stay set.
- R9: While bit 2 is 1, `serr_n` is 0 for exactly the cycle of each discard pulse. While bit 2 is 0, `serr_n` stays 1.
- R10: The two sides time independently. When both expire on the same edge, both discard outputs pulse and `serr_n` goes low for a single cycle.
- R11: A change of select takes effect one edge after the write. A count already beyond the new limit then expires at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wdata | input | 5 | Register write data |
| csr_rdata | output | 5 | Register read data |
| pri_head_vld | input | 1 | Primary queue head holds a delayed request |
| pri_repeat_seen | input | 1 | Primary initiator repeated the head request |
| sec_head_vld | input | 1 | Secondary queue head holds a delayed request |
| sec_repeat_seen | input | 1 | Secondary initiator repeated the head request |
| pri_discard | output | 1 | One-cycle pulse: pop primary head entry |
| sec_discard | output | 1 | One-cycle pulse: pop secondary head entry |
| serr_n | output | 1 | Active-low system error pulse |

## Verification
The hardware setting of the status flags on an expiry can coincide with a software write that clears the same flags. The bench counts a short-window entry to one edge before its limit. It then issues the write-one-to-clear so that the write lands on the expiring edge. The flags must read as set afterwards, and a later clear must still work. A second coincidence, a repeat arriving on the expiring edge, is driven the same way and must suppress the discard.

// File: rtl/drq_pkg.sv
package drq_pkg;
    localparam int CSR_W     = 5;
    localparam int N_SIDE    = 2;
    localparam int SIDE_PRI  = 0;
    localparam int SIDE_SEC  = 1;
    localparam int B_PSHORT  = 0;
    localparam int B_SSHORT  = 1;
    localparam int B_SERR_EN = 2;
    localparam int B_TMO     = 3;
    localparam int B_DISC    = 4;

    // packed so that field positions match the bit layout above
    typedef struct packed {
        logic              disc_stat;
        logic              tmo_stat;
        logic              serr_en;
        logic [N_SIDE-1:0] short_sel;
    } csr_t;
endpackage

// File: rtl/drq_side_timer.sv
module drq_side_timer #(
    parameter int LONG_LOG2  = 15,
    parameter int SHORT_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic head_vld,
    input  logic repeat_seen,
    input  logic short_sel,
    output logic hit,
    output logic discard
);
    localparam int CNT_W = LONG_LOG2;
    localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((1 << SHORT_LOG2) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             served;
        logic             discard;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt     = short_sel ? SHORT_LAST : LONG_LAST;
        hit          = 1'b0;
        st_d         = st_q;
        st_d.discard = 1'b0;
        if (!head_vld) begin
            st_d.cnt    = '0;
            st_d.served = 1'b0;
        end else if (repeat_seen) begin
            st_d.cnt    = '0;
            st_d.served = 1'b1;
        end else if (!st_q.served) begin
            if (st_q.cnt >= last_cnt) begin
                hit      = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (hit) st_d.discard = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign discard = st_q.discard;
endmodule

// File: rtl/drq_csr.sv
module drq_csr
    import drq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wdata,
    input  logic             expire_any,
    output csr_t             csr
);
    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (wr_en) begin
            csr_d.short_sel = wdata[B_SSHORT:B_PSHORT];
            csr_d.serr_en   = wdata[B_SERR_EN];
            if (wdata[B_TMO])  csr_d.tmo_stat  = 1'b0;
            if (wdata[B_DISC]) csr_d.disc_stat = 1'b0;
        end
        // hardware set is applied last so it wins over a clear
        if (expire_any) begin
            csr_d.tmo_stat  = 1'b1;
            csr_d.disc_stat = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    assign csr = csr_q;
endmodule

// File: rtl/drq_discard_timers.sv
module drq_discard_timers
    import drq_pkg::*;
#(
    parameter int LONG_LOG2  = 15,
    parameter int SHORT_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr_en,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             pri_head_vld,
    input  logic             pri_repeat_seen,
    input  logic             sec_head_vld,
    input  logic             sec_repeat_seen,
    output logic             pri_discard,
    output logic             sec_discard,
    output logic             serr_n
);
    typedef struct packed {
        logic serr_n;
    } top_t;

    logic [N_SIDE-1:0] head_vld, repeat_seen, hit, discard;
    csr_t csr;
    top_t top_d, top_q;
    logic expire_any;

    assign head_vld[SIDE_PRI]    = pri_head_vld;
    assign head_vld[SIDE_SEC]    = sec_head_vld;
    assign repeat_seen[SIDE_PRI] = pri_repeat_seen;
    assign repeat_seen[SIDE_SEC] = sec_repeat_seen;

    for (genvar g = 0; g < N_SIDE; g++) begin : g_side
        drq_side_timer #(
            .LONG_LOG2 (LONG_LOG2),
            .SHORT_LOG2(SHORT_LOG2)
        ) u_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .head_vld   (head_vld[g]),
            .repeat_seen(repeat_seen[g]),
            .short_sel  (csr.short_sel[g]),
            .hit        (hit[g]),
            .discard    (discard[g])
        );
    end

    assign expire_any = |hit;

    drq_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (csr_wr_en),
        .wdata     (csr_wdata),
        .expire_any(expire_any),
        .csr       (csr)
    );

    always_comb begin
        top_d        = top_q;
        top_d.serr_n = !(expire_any && csr.serr_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{serr_n: 1'b1};
        else        top_q <= top_d;
    end

    assign csr_rdata   = csr;
    assign pri_discard = discard[SIDE_PRI];
    assign sec_discard = discard[SIDE_SEC];
    assign serr_n      = top_q.serr_n;
endmodule

// File: rtl/drq_checker.sv
module drq_checker
    import drq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CSR_W-1:0] csr_rdata,
    input logic             pri_head_vld,
    input logic             pri_repeat_seen,
    input logic             sec_head_vld,
    input logic             sec_repeat_seen,
    input logic             pri_discard,
    input logic             sec_discard,
    input logic             serr_n
);
    p_pri_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pri_discard |=> !pri_discard);
    p_sec_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_discard |=> !sec_discard);
    p_pri_needs_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_head_vld |=> !pri_discard);
    p_sec_needs_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_head_vld |=> !sec_discard);
    p_pri_repeat_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pri_repeat_seen |=> !pri_discard);
    p_sec_repeat_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_repeat_seen |=> !sec_discard);
    p_status_on_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_discard || sec_discard) |-> (csr_rdata[B_TMO] && csr_rdata[B_DISC]));
    p_serr_with_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> (pri_discard || sec_discard));
    p_serr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |=> serr_n);
endmodule

bind drq_discard_timers drq_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .csr_rdata      (csr_rdata),
    .pri_head_vld   (pri_head_vld),
    .pri_repeat_seen(pri_repeat_seen),
    .sec_head_vld   (sec_head_vld),
    .sec_repeat_seen(sec_repeat_seen),
    .pri_discard    (pri_discard),
    .sec_discard    (sec_discard),
    .serr_n         (serr_n)
);

// File: tb/drq_discard_timers_tb.sv
module drq_discard_timers_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LONG_N  = 32768;
    localparam int SHORT_N = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_wr_en = 1'b0;
    logic [4:0] csr_wdata = '0;
    logic [4:0] csr_rdata;
    logic       pri_head_vld = 1'b0, pri_repeat_seen = 1'b0;
    logic       sec_head_vld = 1'b0, sec_repeat_seen = 1'b0;
    logic       pri_discard, sec_discard, serr_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    drq_discard_timers u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .csr_wr_en      (csr_wr_en),
        .csr_wdata      (csr_wdata),
        .csr_rdata      (csr_rdata),
        .pri_head_vld   (pri_head_vld),
        .pri_repeat_seen(pri_repeat_seen),
        .sec_head_vld   (sec_head_vld),
        .sec_repeat_seen(sec_repeat_seen),
        .pri_discard    (pri_discard),
        .sec_discard    (sec_discard),
        .serr_n         (serr_n)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic csr_write(logic [4:0] v);
        csr_wr_en = 1'b1;
        csr_wdata = v;
        tick(1);
        csr_wr_en = 1'b0;
        csr_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R1", "rdata", csr_rdata, 0);
        chk("R1", "pri_discard", pri_discard, 0);
        chk("R1", "sec_discard", sec_discard, 0);
        chk("R1", "serr_n", serr_n, 1);
    endtask

    task automatic t_short_primary();
        csr_write(5'b00101);
        chk("R7", "config readback", csr_rdata, 5'b00101);
        pri_head_vld = 1'b1;
        tick(SHORT_N - 1);
        chk("R3", "no discard before limit", pri_discard, 0);
        tick(1);
        chk("R3", "discard at limit", pri_discard, 1);
        chk("R9", "serr_n low with discard", serr_n, 0);
        chk("R7", "status set", csr_rdata, 5'b11101);
        chk("R10", "other side quiet", sec_discard, 0);
        tick(1);
        chk("R4", "pulse one cycle", pri_discard, 0);
        chk("R9", "serr_n back high", serr_n, 1);
        tick(SHORT_N - 2);
        chk("R4", "restart: not early", pri_discard, 0);
        tick(1);
        chk("R4", "restart: next pulse", pri_discard, 1);
        pri_head_vld = 1'b0;
        csr_write(5'b00101);
        chk("R7", "write 0 keeps status", csr_rdata, 5'b11101);
        csr_write(5'b11101);
        chk("R7", "w1c clears status", csr_rdata, 5'b00101);
    endtask

    task automatic t_long_secondary();
        int lows = 0;
        csr_write(5'b00001);
        sec_head_vld = 1'b1;
        for (int i = 0; i < LONG_N - 1; i++) begin
            tick(1);
            if (!serr_n) lows++;
        end
        chk("R2", "no discard before long limit", sec_discard, 0);
        tick(1);
        chk("R2", "discard at long limit", sec_discard, 1);
        chk("R9", "serr_n high when disabled", serr_n, 1);
        chk("R7", "status set by secondary", csr_rdata, 5'b11001);
        chk("R9", "no serr pulses while disabled", lows, 0);
        sec_head_vld = 1'b0;
        csr_write(5'b11000);
        chk("R7", "cleared", csr_rdata, 5'b00000);
    endtask

    task automatic t_repeat();
        int seen = 0;
        csr_write(5'b00010);
        sec_head_vld = 1'b1;
        tick(500);
        sec_repeat_seen = 1'b1;
        tick(1);
        sec_repeat_seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            tick(1);
            if (sec_discard) seen++;
        end
        chk("R5", "no discard after repeat", seen, 0);
        sec_head_vld = 1'b0;
        tick(1);
        sec_head_vld = 1'b1;
        tick(SHORT_N - 1);
        chk("R5", "new entry not early", sec_discard, 0);
        tick(1);
        chk("R5", "new entry timed from zero", sec_discard, 1);
        sec_head_vld = 1'b0;
        csr_write(5'b11000);
    endtask

    task automatic t_repeat_at_limit();
        int seen = 0;
        csr_write(5'b00001);
        pri_head_vld = 1'b1;
        tick(SHORT_N - 1);
        pri_repeat_seen = 1'b1;
        tick(1);
        pri_repeat_seen = 1'b0;
        chk("R6", "repeat at expiring edge", pri_discard, 0);
        for (int i = 0; i < 1100; i++) begin
            tick(1);
            if (pri_discard) seen++;
        end
        chk("R6", "stays quiet after repeat", seen, 0);
        chk("R6", "no status set", csr_rdata, 5'b00001);
        pri_head_vld = 1'b0;
        tick(1);
    endtask

    task automatic t_both();
        int lows = 0;
        csr_write(5'b00111);
        pri_head_vld = 1'b1;
        sec_head_vld = 1'b1;
        tick(SHORT_N);
        chk("R10", "primary pulses", pri_discard, 1);
        chk("R10", "secondary pulses", sec_discard, 1);
        for (int i = 0; i < 4; i++) begin
            if (!serr_n) lows++;
            tick(1);
        end
        chk("R10", "single serr cycle", lows, 1);
        pri_head_vld = 1'b0;
        sec_head_vld = 1'b0;
        csr_write(5'b11000);
    endtask

    task automatic t_collide();
        csr_write(5'b00001);
        pri_head_vld = 1'b1;
        tick(SHORT_N - 1);
        csr_write(5'b11001);
        chk("R8", "discard on collision edge", pri_discard, 1);
        chk("R8", "set wins over clear", csr_rdata, 5'b11001);
        pri_head_vld = 1'b0;
        csr_write(5'b11000);
        chk("R8", "later clear works", csr_rdata, 5'b00000);
    endtask

    task automatic t_sel_change();
        pri_head_vld = 1'b1;
        tick(2000);
        csr_write(5'b00001);
        chk("R11", "old select at write edge", pri_discard, 0);
        tick(1);
        chk("R11", "expire next edge", pri_discard, 1);
        pri_head_vld = 1'b0;
        csr_write(5'b11000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_short_primary();
        t_long_secondary();
        t_repeat();
        t_repeat_at_limit();
        t_both();
        t_collide();
        t_sel_change();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule